// File: doc/BRIEF.md
# Table-Programmed Bit-Slice Arithmetic Unit

This block is a WIDTH-bit arithmetic and logic unit made of identical one-bit slices. Its function is not picked by a decoded opcode. Each slice looks up its outputs in two 8-entry truth tables. The first table gives the result bit. The second gives the carry that feeds the slice above it. Every slice uses the same pair of tables, and both tables come from one 16-bit configuration word.

Software or a controller sets the function by presenting a configuration word and pulsing the load strobe for one clock. From then on, the result and the carry-out follow the operands combinationally. With the right table contents the unit can add with carry, compute B minus A, do XOR, AND and invert, and shift B left by one place. The operand and result paths are plain combinational signals with no handshake. The block holds no data, so it never applies back-pressure.

Top module: `lutalu_core`

## Requirements
- R1: Reset clears the stored configuration word to 16'h0000. Until the next load, every result bit and the carry-out are 0 for any operands.
- R2: The configuration register takes `cfg_word` only at a rising clock edge while `cfg_load` is 1. When `cfg_load` is 0, changes on `cfg_word` have no effect on the outputs.
- R3: Bits [7:0] of the stored word form the result table and bits [15:8] form the carry table. For slice i, the table index is k = {a_i, b_i, c_i}, with a_i as the most significant bit. Table entry k (bit k) is the output for that index.
- R4: Slice 0 takes its carry from `cin`. Slice i+1 takes the carry-table output of slice i. `cout` is the carry-table output of the top slice.
- R5: With configuration 16'hE896, {cout, res} equals a + b + cin.
- R6: With configuration 16'h8E69 and cin = 1, res equals (b - a) modulo 2^WIDTH, and cout is 1 exactly when b >= a (unsigned).
- R7: Three configurations give the logic operations, each with its carry squashed so that cout = 0: 16'h003C gives a ^ b, 16'h00C0 gives a & b, and 16'h000F gives ~a.
- R8: With configuration 16'hCCAA and cin = 0, res equals b shifted left by one with bit 0 cleared, and cout equals the top bit of b.
- R9: `res` and `cout` respond to operand and `cin` changes within the same cycle, with no clock edge between the change and the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the configuration register |
| rst_n | input | 1 | Active-low synchronous reset |
| a_in | input | WIDTH | Operand A |
| b_in | input | WIDTH | Operand B |
| cin | input | 1 | Carry into slice 0 |
| cfg_word | input | 16 | Configuration word: carry table in [15:8], result table in [7:0] |
| cfg_load | input | 1 | Strobe; loads cfg_word at the clock edge |
| res | output | WIDTH | Result |
| cout | output | 1 | Carry out of the top slice |

## Verification
The assertions run on every cycle and check four things. The configuration must hold when no load is present and must capture the word when one is. The outputs must be zero right after reset. Whenever the stored word matches the add, subtract or shift encoding, the outputs must agree with the arithmetic. The bench scenarios cover what those properties cannot reach. They exercise arbitrary table contents that check the index order, and they show the carry rippling through every slice. They also show that a word presented without a load is ignored, and that the outputs follow operand changes within the same cycle.

// File: rtl/lutalu_pkg.sv
package lutalu_pkg;
  localparam int TBL_W = 8;
  localparam int CFG_W = 2 * TBL_W;

  typedef struct packed {
    logic [TBL_W-1:0] cry_tbl;
    logic [TBL_W-1:0] sum_tbl;
  } lut_cfg_t;

  // Look up entry {a,b,c} of an 8-entry truth table, a being the MSB of the index.
  function automatic logic lut3(input logic [TBL_W-1:0] tbl, input logic a,
                                input logic b, input logic c);
    return tbl[{a, b, c}];
  endfunction
endpackage

// File: rtl/lutalu_cfg_reg.sv
module lutalu_cfg_reg
  import lutalu_pkg::*;
#(
  parameter logic [CFG_W-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CFG_W-1:0] cfg_d,
  output lut_cfg_t         cfg_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    cfg_q <= lut_cfg_t'(RST_VAL);
    else if (load) cfg_q <= lut_cfg_t'(cfg_d);
  end

  // R2: without a strobe the stored tables do not move
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(cfg_q));
  // R2: with a strobe the word presented at the edge is captured
  a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cfg_q == $past(cfg_d)));
endmodule

// File: rtl/lutalu_slice.sv
module lutalu_slice
  import lutalu_pkg::*;
(
  input  lut_cfg_t cfg,
  input  logic     a_bit,
  input  logic     b_bit,
  input  logic     c_in,
  output logic     r_bit,
  output logic     c_out
);
  always_comb begin
    r_bit = lut3(cfg.sum_tbl, a_bit, b_bit, c_in);
    c_out = lut3(cfg.cry_tbl, a_bit, b_bit, c_in);
  end
endmodule

// File: rtl/lutalu_core.sv
module lutalu_core
  import lutalu_pkg::*;
#(
  parameter int               WIDTH   = 8,
  parameter logic [CFG_W-1:0] RST_CFG = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  logic             cin,
  input  logic [CFG_W-1:0] cfg_word,
  input  logic             cfg_load,
  output logic [WIDTH-1:0] res,
  output logic             cout
);
  localparam int EXT_W = WIDTH + 1;

  lut_cfg_t         cfg_q;
  logic [WIDTH:0]   chain;

  lutalu_cfg_reg #(.RST_VAL(RST_CFG)) cfg_i (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (cfg_load),
    .cfg_d (cfg_word),
    .cfg_q (cfg_q)
  );

  assign chain[0] = cin;

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    lutalu_slice slice_i (
      .cfg   (cfg_q),
      .a_bit (a_in[i]),
      .b_bit (b_in[i]),
      .c_in  (chain[i]),
      .r_bit (res[i]),
      .c_out (chain[i+1])
    );
  end

  assign cout = chain[WIDTH];

  // R1: first cycle out of reset, all-zero tables give zero outputs
  a_r1_reset_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rst_n) && RST_CFG == '0) |-> (res == '0 && !cout));
  // R5: add encoding matches integer addition
  a_r5_add: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q == 16'hE896) |->
      ({cout, res} == (EXT_W'(a_in) + EXT_W'(b_in) + EXT_W'(cin))));
  // R6: subtract encoding with carry-in set gives b - a and no-borrow flag
  a_r6_sub: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q == 16'h8E69 && cin) |->
      (res == WIDTH'(b_in - a_in) && cout == (b_in >= a_in)));
  // R8: shift encoding moves b up one place
  a_r8_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q == 16'hCCAA && !cin) |->
      (res == {b_in[WIDTH-2:0], 1'b0} && cout == b_in[WIDTH-1]));
endmodule

// File: tb/lutalu_core_tb.sv
module lutalu_core_tb_top;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic         cin = 1'b0;
  logic [15:0]  cfg_word = '0;
  logic         cfg_load = 1'b0;
  logic [W-1:0] res;
  logic         cout;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [15:0] model_cfg = 16'h0000;

  always #2 clk = ~clk;

  lutalu_core #(.WIDTH(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in), .cin(cin),
    .cfg_word(cfg_word), .cfg_load(cfg_load), .res(res), .cout(cout)
  );

  // Reference: ripple through the tables bit by bit
  function automatic logic [W:0] model(input logic [15:0] c, input logic [W-1:0] a,
                                       input logic [W-1:0] b, input logic ci);
    logic [W-1:0] r;
    logic cy;
    cy = ci;
    for (int i = 0; i < W; i++) begin
      int idx;
      idx = (a[i] ? 4 : 0) + (b[i] ? 2 : 0) + (cy ? 1 : 0);
      r[i] = c[idx];
      cy   = c[8 + idx];
    end
    return {cy, r};
  endfunction

  task automatic chk(input string req, input logic [W:0] act, input logic [W:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive after a falling edge, compare against the model before the next rising edge
  task automatic step(input string req, input logic [W-1:0] a, input logic [W-1:0] b,
                      input logic ci, input logic [15:0] cw, input logic ld);
    @(negedge clk);
    a_in = a; b_in = b; cin = ci; cfg_word = cw; cfg_load = ld;
    #1;
    chk(req, {cout, res}, model(model_cfg, a, b, ci));
    @(posedge clk);
    if (ld && rst_n) model_cfg = cw;
    #0.5;
    cfg_load = 1'b0;
  endtask

  task automatic load(input logic [15:0] cw);
    step("R2", '0, '0, 1'b0, cw, 1'b1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1: zero after reset
    step("R1", 8'hFF, 8'hFF, 1'b1, 16'hFFFF, 1'b0);
    #1 chk("R1", {cout, res}, '0);
    // R2: word without load ignored
    step("R2", 8'h5A, 8'hA5, 1'b0, 16'hE896, 1'b0);
    #1 chk("R2", {cout, res}, '0);

    // R5: add
    load(16'hE896);
    for (int t = 0; t < 40; t++) begin
      logic [W-1:0] a, b; logic ci;
      a = W'(t * 37 + 11); b = W'(t * 91 + 200); ci = t[0];
      step("R5", a, b, ci, 16'h0000, 1'b0);
      #1 chk("R5", {cout, res}, {1'b0, a} + {1'b0, b} + (W+1)'(ci));
    end
    // R4: carry ripples through every slice, cin enters slice 0
    step("R4", 8'hFF, 8'h00, 1'b1, 16'h0, 1'b0);
    #1 chk("R4", {cout, res}, 9'h100);
    step("R4", 8'hFF, 8'h00, 1'b0, 16'h0, 1'b0);
    #1 chk("R4", {cout, res}, 9'h0FF);

    // R6: b - a
    load(16'h8E69);
    for (int t = 0; t < 30; t++) begin
      logic [W-1:0] a, b;
      a = W'(t * 53 + 3); b = W'(t * 29 + 7);
      step("R6", a, b, 1'b1, 16'h0, 1'b0);
      #1 chk("R6", {cout, res}, {b >= a, W'(b - a)});
    end

    // R7: logic ops, carry squashed
    load(16'h003C);
    step("R7", 8'hC3, 8'h5A, 1'b1, 16'h0, 1'b0);
    #1 chk("R7", {cout, res}, {1'b0, 8'hC3 ^ 8'h5A});
    load(16'h00C0);
    step("R7", 8'hC3, 8'h5A, 1'b1, 16'h0, 1'b0);
    #1 chk("R7", {cout, res}, {1'b0, 8'hC3 & 8'h5A});
    load(16'h000F);
    step("R7", 8'hC3, 8'h5A, 1'b1, 16'h0, 1'b0);
    #1 chk("R7", {cout, res}, {1'b0, ~8'hC3});

    // R8: shift b left
    load(16'hCCAA);
    step("R8", 8'h00, 8'hB5, 1'b0, 16'h0, 1'b0);
    #1 chk("R8", {cout, res}, {1'b1, 8'h6A});
    step("R8", 8'hFF, 8'h41, 1'b0, 16'h0, 1'b0);
    #1 chk("R8", {cout, res}, {1'b0, 8'h82});

    // R3: single-entry tables probe the index order {a,b,c}
    for (int k = 0; k < 8; k++) begin
      logic [15:0] cw;
      cw = 16'(1 << k);
      load(cw);
      step("R3", {W{k[2]}}, {W{k[1]}}, k[0], 16'h0, 1'b0);
      #1 chk("R3", res[0], 9'd1);
    end

    // R9: same-cycle response, no edge between operand change and output
    load(16'hE896);
    @(negedge clk);
    a_in = 8'h10; b_in = 8'h01; cin = 1'b0; #0.5;
    chk("R9", {cout, res}, 9'h011);
    a_in = 8'hF0; b_in = 8'h20; #0.5;
    chk("R9", {cout, res}, 9'h110);

    // R2: reload while another word waits unloaded
    step("R2", 8'h0F, 8'hF0, 1'b0, 16'h00C0, 1'b0);
    #1 chk("R2", {cout, res}, 9'h0FF);

    // R1: reset again clears the tables
    @(negedge clk); rst_n = 1'b0;
    @(posedge clk); model_cfg = 16'h0000;
    @(negedge clk); rst_n = 1'b1;
    step("R1", 8'h77, 8'h88, 1'b1, 16'h0, 1'b0);

    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule